// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable logic cell meant to be repeated across a tiled array. It has three operands. Each operand is taken from one of eight neighbour wires, and a 3-bit code picks which one. A function byte sets what the cell computes. It can be any Boolean function of two operands, which includes a buffer, an inverter and the two constants. It can instead be a 2:1 multiplexer in which the third operand does the selecting and either data leg may be inverted. The result can go straight to the output or pass through a D flip-flop. The flip-flop clears on a synchronous reset and also on an asynchronous global clear.

The cell result is copied onto up to four directional outputs, and a mask enables each one. The function byte and the routing bits (operand codes and direction mask) are loaded through a byte-wide write port. A write takes effect at the clock edge that samples it. A write does not touch the value held in the flip-flop.

Top module: `fgcell`

## Requirements
- R1: When `rst` is high at a rising clock edge, the function byte, the routing bits and the flip-flop are all cleared, so `cell_out` and `out_dir` read 0 afterwards.
- R2: The routing word is 13 bits. Operand a is `nbr_in[route[2:0]]`, operand b is `nbr_in[route[5:3]]` and operand c is `nbr_in[route[8:6]]`.
- R3: When function byte bit 0 is 0 (table mode), the combinational result is bit `4 + 2*b + a` of the function byte. This gives every 2-input function: buffer of a = 0xA0, buffer of b = 0xC0, constant 0 = 0x00, constant 1 = 0xF0.
- R4: When function byte bit 0 is 1 (mux mode), the combinational result is `c ? (b ^ fn[5]) : (a ^ fn[4])`.
- R5: When function byte bit 1 is 1, `cell_out` is the flip-flop, which loads the combinational result at every rising edge. When bit 1 is 0, `cell_out` follows the combinational result in the same cycle.
- R6: While `gclr` is high, the flip-flop is 0 at once, without waiting for a clock edge. It stays 0 at clock edges for as long as `gclr` stays high.
- R7: A write with `cfg_we` high at a rising edge loads one of three targets, chosen by the address:
  - address 0 loads the function byte;
  - address 1 loads `route[7:0]`;
  - address 2 loads `route[12:8]` from `cfg_wdata[4:0]`.

  The new setting applies after that edge. A flip-flop capture at the same edge still uses the old setting, and a write never changes the stored flip-flop value.
- R8: `out_dir[i]` equals `cell_out` when mask bit `route[9+i]` is 1, and is 0 otherwise.
- R9: Some writes and bits have no effect:
  - writes to address 3;
  - function byte bits 3:2;
  - `cfg_wdata[7:5]` on an address-2 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gclr | input | 1 | Asynchronous active-high clear of the cell flip-flop |
| nbr_in | input | 8 | Neighbour source wires |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cell_out | output | 1 | Cell result |
| out_dir | output | 4 | Cell result gated onto each direction |

## Verification
Two events can fall on the same clock edge: a configuration write and a flip-flop capture in registered mode. The bench sets up a registered constant-1 cell and then writes a constant-0 function byte while the flip-flop is capturing. It expects a 1 right after that edge and a 0 only one edge later. The bench also pulses the global clear mid-cycle, both in registered mode and around writes, and expects the output to drop before the next edge. Random configurations, inputs and clears are compared cycle by cycle against a model of the requirements.

// File: rtl/fgcell_pkg.sv
package fgcell_pkg;

  localparam int BYTE_W = 8;
  localparam int NOPER  = 3;

  typedef enum logic {
    MODE_TABLE = 1'b0,
    MODE_MUX   = 1'b1
  } fmode_e;

  // function byte: [7:4] truth table, [3:2] unused, [1] registered, [0] mode
  typedef struct packed {
    logic [3:0] tt;
    logic       regd;
    fmode_e     mode;
  } fn_cfg_t;

endpackage

// File: rtl/fgcell_cfg.sv
module fgcell_cfg
  import fgcell_pkg::*;
#(
  parameter int ROUTE_W = 13,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wdata,
  output fn_cfg_t            fn,
  output logic [ROUTE_W-1:0] route
);

  localparam int RBYTES = (ROUTE_W + BYTE_W - 1) / BYTE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      fn <= '0;
    end else if (we && addr == '0) begin
      fn.tt   <= wdata[7:4];
      fn.regd <= wdata[1];
      fn.mode <= fmode_e'(wdata[0]);
    end
  end

  for (genvar rb = 0; rb < RBYTES; rb++) begin : g_rbyte
    localparam int LO = rb * BYTE_W;
    localparam int HI = (LO + BYTE_W > ROUTE_W) ? ROUTE_W - 1 : LO + BYTE_W - 1;
    localparam int W  = HI - LO + 1;
    logic [W-1:0] part_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        part_q <= '0;
      end else if (we && addr == ADDR_W'(rb + 1)) begin
        part_q <= wdata[W-1:0];
      end
    end

    assign route[HI:LO] = part_q;
  end

endmodule

// File: rtl/fgcell_insel.sv
module fgcell_insel #(
  parameter int NSRC  = 8,
  parameter int SEL_W = 3
) (
  input  logic [NSRC-1:0]  src,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  always_comb begin
    y = src[sel];
  end

endmodule

// File: rtl/fgcell_func.sv
module fgcell_func
  import fgcell_pkg::*;
(
  input  logic [3:0] tt,
  input  fmode_e     mode,
  input  logic       a,
  input  logic       b,
  input  logic       c,
  output logic       y
);

  always_comb begin
    unique case (mode)
      MODE_TABLE: y = tt[{b, a}];
      MODE_MUX:   y = c ? (b ^ tt[1]) : (a ^ tt[0]);
      default:    y = 1'b0;
    endcase
  end

endmodule

// File: rtl/fgcell_outreg.sv
module fgcell_outreg #(
  parameter int NDIR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gclr,
  input  logic            d,
  input  logic            regd,
  input  logic [NDIR-1:0] dir_en,
  output logic            q,
  output logic            cell_out,
  output logic [NDIR-1:0] out_dir
);

  always_ff @(posedge clk or posedge gclr) begin
    if (gclr) begin
      q <= 1'b0;
    end else if (rst) begin
      q <= 1'b0;
    end else begin
      q <= d;
    end
  end

  assign cell_out = regd ? q : d;

  for (genvar i = 0; i < NDIR; i++) begin : g_dir
    assign out_dir[i] = dir_en[i] & cell_out;
  end

endmodule

// File: rtl/fgcell.sv
module fgcell
  import fgcell_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NDIR   = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gclr,
  input  logic [NSRC-1:0]   nbr_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic              cell_out,
  output logic [NDIR-1:0]   out_dir
);

  localparam int SEL_W   = $clog2(NSRC);
  localparam int ROUTE_W = NOPER * SEL_W + NDIR;

  fn_cfg_t            fn_q;
  logic [ROUTE_W-1:0] route_q;
  logic [NOPER-1:0]   opnd;
  logic               f_val;
  logic               q_r;

  fgcell_cfg #(.ROUTE_W(ROUTE_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .fn    (fn_q),
    .route (route_q)
  );

  for (genvar k = 0; k < NOPER; k++) begin : g_sel
    fgcell_insel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
      .src (nbr_in),
      .sel (route_q[k*SEL_W +: SEL_W]),
      .y   (opnd[k])
    );
  end

  fgcell_func u_func (
    .tt   (fn_q.tt),
    .mode (fn_q.mode),
    .a    (opnd[0]),
    .b    (opnd[1]),
    .c    (opnd[2]),
    .y    (f_val)
  );

  fgcell_outreg #(.NDIR(NDIR)) u_out (
    .clk      (clk),
    .rst      (rst),
    .gclr     (gclr),
    .d        (f_val),
    .regd     (fn_q.regd),
    .dir_en   (route_q[NOPER*SEL_W +: NDIR]),
    .q        (q_r),
    .cell_out (cell_out),
    .out_dir  (out_dir)
  );

endmodule

// File: rtl/fgcell_chk.sv
module fgcell_chk
  import fgcell_pkg::*;
#(
  parameter int NDIR    = 4,
  parameter int ROUTE_W = 13,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               gclr,
  input logic               cfg_we,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic [BYTE_W-1:0]  cfg_wdata,
  input fn_cfg_t            fn,
  input logic [ROUTE_W-1:0] route,
  input logic               f_val,
  input logic               q,
  input logic               cell_out,
  input logic [NDIR-1:0]    out_dir
);

  localparam int RBYTES = (ROUTE_W + BYTE_W - 1) / BYTE_W;
  localparam int DIR_LO = ROUTE_W - NDIR;

  // R1: reset clears configuration and flip-flop
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (gclr)
    rst |=> (fn == '0 && route == '0 && q == 1'b0));

  // R5: flip-flop holds the result sampled at the previous edge
  a_r5_capture: assert property (@(posedge clk) disable iff (rst || gclr)
    1'b1 |=> q == $past(f_val));

  // R6: global clear keeps the flip-flop at 0
  a_r6_gclr: assert property (@(posedge clk) disable iff (rst)
    gclr |-> q == 1'b0);

  // R7: function byte load
  a_r7_fn_load: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == '0) |=>
      {fn.tt, fn.regd, fn.mode} == {$past(cfg_wdata[7:4]), $past(cfg_wdata[1:0])});

  // R9: writes above the routing bytes change nothing
  a_r9_unused_addr: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_addr) > RBYTES) |=> ($stable(fn) && $stable(route)));

  // R8: direction outputs only where enabled and only when the cell is high
  a_r8_dir_gate: assert property (@(posedge clk) disable iff (rst)
    ((out_dir & ~route[DIR_LO +: NDIR]) == '0) && (cell_out || out_dir == '0));

endmodule

bind fgcell fgcell_chk #(.NDIR(NDIR), .ROUTE_W(ROUTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gclr      (gclr),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .fn        (fn_q),
  .route     (route_q),
  .f_val     (f_val),
  .q         (q_r),
  .cell_out  (cell_out),
  .out_dir   (out_dir)
);

// File: tb/sim_fgcell.sv
module sim_fgcell;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gclr = 1'b0;
  logic [7:0] nbr_in = 8'h00;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       cell_out;
  logic [3:0] out_dir;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  m_fn = 8'h00;
  logic [12:0] m_route = 13'h0;
  logic        m_q = 1'b0;

  always #10 clk = ~clk;

  fgcell u0 (
    .clk       (clk),
    .rst       (rst),
    .gclr      (gclr),
    .nbr_in    (nbr_in),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cell_out  (cell_out),
    .out_dir   (out_dir)
  );

  function automatic logic comb_of(logic [7:0] fn, logic [12:0] rt, logic [7:0] nb);
    logic a, b, c;
    a = nb[rt[2:0]];
    b = nb[rt[5:3]];
    c = nb[rt[8:6]];
    if (!fn[0]) return fn[4 + {b, a}];
    return c ? (b ^ fn[5]) : (a ^ fn[4]);
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] addr, input logic [7:0] data,
                     input logic [7:0] nbr, input logic clr, input logic rs, input string tag);
    logic eo;
    string t;
    @(negedge clk);
    cfg_we = we; cfg_addr = addr; cfg_wdata = data;
    nbr_in = nbr; gclr = clr; rst = rs;
    #1;
    if (clr) m_q = 1'b0;
    eo = m_fn[1] ? m_q : comb_of(m_fn, m_route, nbr);
    t = (tag != "") ? tag : (m_fn[1] ? "R5" : (m_fn[0] ? "R4" : "R3"));
    check(t, {3'b0, cell_out}, {3'b0, eo});
    check((tag != "") ? tag : "R8", out_dir, m_route[12:9] & {4{eo}});
    @(posedge clk);
    if (rs || clr) m_q = 1'b0;
    else m_q = comb_of(m_fn, m_route, nbr);
    if (rs) begin
      m_fn = 8'h00; m_route = 13'h0;
    end else if (we) begin
      case (addr)
        2'd0: m_fn = data;
        2'd1: m_route[7:0] = data;
        2'd2: m_route[12:8] = data[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [1:0] addr, input logic [7:0] data, input logic [7:0] nbr);
    cyc(1'b1, addr, data, nbr, 1'b0, 1'b0, "");
  endtask

  task automatic set_route(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sc,
                           input logic [3:0] dir);
    logic [12:0] r;
    r = {dir, sc, sb, sa};
    wr(2'd1, r[7:0], 8'h00);
    wr(2'd2, {3'b000, r[12:8]}, 8'h00);
  endtask

  task automatic idle(input logic [7:0] nbr, input string tag);
    cyc(1'b0, 2'd0, 8'h00, nbr, 1'b0, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd2718));
    // R1: reset state
    cyc(1'b0, 2'd0, 8'h00, 8'hFF, 1'b0, 1'b1, "R1");
    cyc(1'b0, 2'd0, 8'h00, 8'hFF, 1'b0, 1'b1, "R1");
    // R1: reset wipes a loaded constant-1 configuration
    wr(2'd0, 8'hF0, 8'h00);
    set_route(3'd0, 3'd1, 3'd2, 4'hF);
    idle(8'h00, "R3");
    cyc(1'b0, 2'd0, 8'h00, 8'hFF, 1'b0, 1'b1, "R1");
    idle(8'hFF, "R1");

    // R2: operand a from each source (buffer of a)
    wr(2'd0, 8'hA0, 8'h00);
    for (int k = 0; k < 8; k++) begin
      set_route(3'(k), 3'(7 - k), 3'd0, 4'hF);
      idle(8'(1 << k), "R2");
      idle(~8'(1 << k), "R2");
    end
    // R2: operand b from each source (buffer of b)
    wr(2'd0, 8'hC0, 8'h00);
    for (int k = 0; k < 8; k++) begin
      set_route(3'(7 - k), 3'(k), 3'd0, 4'h5);
      idle(8'(1 << k), "R2");
      idle(~8'(1 << k), "R2");
    end
    // R2 / R4: operand c through mux with inverted a leg
    wr(2'd0, 8'h11, 8'h00);
    for (int k = 0; k < 7; k++) begin
      set_route(3'd7, 3'd7, 3'(k), 4'hA);
      idle(8'(1 << k), "R2");
      idle(8'h00, "R2");
    end

    // R3: constants and inverter
    set_route(3'd0, 3'd1, 3'd2, 4'hF);
    wr(2'd0, 8'h00, 8'hFF);
    idle(8'hFF, "R3");
    wr(2'd0, 8'hF0, 8'h00);
    idle(8'h00, "R3");
    wr(2'd0, 8'h50, 8'h00);
    idle(8'h01, "R3");
    idle(8'h00, "R3");

    // R4: all four mux flavours
    for (int f = 0; f < 4; f++) begin
      wr(2'd0, 8'(f << 4) | 8'h01, 8'h00);
      for (int v = 0; v < 8; v++) idle(8'(v), "R4");
    end

    // R5: registered buffer, output lags one edge
    wr(2'd0, 8'hA2, 8'h00);
    idle(8'h01, "R5");
    idle(8'h00, "R5");
    idle(8'h00, "R5");

    // R7: write and capture on the same edge
    wr(2'd0, 8'hF2, 8'h00);
    idle(8'h00, "R7");
    wr(2'd0, 8'h02, 8'h00);
    idle(8'h00, "R7");
    idle(8'h00, "R7");
    // R7: routing write leaves stored value intact
    wr(2'd0, 8'hF2, 8'h00);
    idle(8'h00, "R7");
    wr(2'd0, 8'h06, 8'h00);
    wr(2'd1, 8'h3F, 8'h00);
    idle(8'h00, "R7");

    // R6: asynchronous clear, held across an edge, then release
    wr(2'd0, 8'hF2, 8'h00);
    idle(8'h00, "R6");
    cyc(1'b0, 2'd0, 8'h00, 8'h00, 1'b1, 1'b0, "R6");
    cyc(1'b0, 2'd0, 8'h00, 8'h00, 1'b1, 1'b0, "R6");
    idle(8'h00, "R6");
    idle(8'h00, "R6");

    // R9: unused address, reserved function bits, upper data bits on route byte 2
    cyc(1'b1, 2'd3, 8'hFF, 8'h00, 1'b0, 1'b0, "R9");
    idle(8'h00, "R9");
    wr(2'd0, 8'hAC, 8'h00);
    idle(8'h01, "R9");
    idle(8'h00, "R9");
    wr(2'd2, 8'hE1, 8'h00);
    idle(8'h01, "R9");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[2:0] < 3'd3, r[4:3], r[12:5], r[20:13], r[27:24] == 4'h0, 1'b0, "");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule